// File: doc/BRIEF.md
# MSI Snooping Cache Controller

This block is the coherence controller for one processor's private data cache on a shared broadcast bus. The cache is a small direct-mapped, write-back array. Each line is in one of three states: Invalid, Shared or Modified. The controller keeps the array coherent with the other caches on the bus using a write-invalidate policy. Processor reads and writes arrive on a request/ready port. A hit completes in the same cycle. A miss holds `cpu_ready` low while the controller arbitrates for the bus and runs one or two transactions.

On the bus side, the controller is a master that issues read-miss, write-miss and writeback commands. Each transaction lasts from the grant to a `bus_done` pulse. Every other master's transaction is presented to the snoop port as a one-cycle pulse. If a snooped miss hits a Modified line, the controller supplies that line's data in the same cycle so memory can be brought up to date. It then downgrades or invalidates the line. The bus serializes all transactions, so a snoop never overlaps this controller's own transaction.

Top module: `msi_snoop_cache`

## Requirements
- R1: After reset every line is Invalid. The first access to any address issues a bus transaction, and with no request `cpu_ready`, `bus_req` and `bus_cmd` are all 0.
- R2: A read whose tag matches a Shared or Modified line raises `cpu_ready` in the request cycle, returns the cached word on `cpu_rdata`, and raises no `bus_req`.
- R3: A write whose tag matches a Modified line raises `cpu_ready` in the request cycle, updates the word, and raises no `bus_req`.
- R4: On a read miss the controller raises `bus_req`. After the grant it drives `bus_cmd`=1 with `bus_addr`=`cpu_addr`. On `bus_done` it raises `cpu_ready` with `bus_rdata` on `cpu_rdata` and installs the line as Shared.
- R5: A write to a line that is Shared or Invalid (or has another tag) issues `bus_cmd`=2. On `bus_done` the line becomes Modified and holds the written word.
- R6: `bus_req` stays high until `bus_gnt`. `bus_cmd` and `bus_addr` stay constant from the grant until `bus_done`. `bus_cmd`=0 when no transaction is in progress.
- R7: A miss whose line holds a Modified copy of a different tag first issues `bus_cmd`=3 with the victim's address and data on `bus_wdata`, then re-arbitrates and issues the miss. The victim state is decided at grant time.
- R8: A snoop with `snp_cmd`=1 that hits a Modified line raises `snp_flush` in the same cycle with the line's word on `snp_data`. The line then becomes Shared: a later read hits and a later write issues a write miss.
- R9: A snoop with `snp_cmd`=2 that hits a Shared or Modified line invalidates it, flushing first if Modified. A later read misses.
- R10: A snoop whose tag differs, that finds the line Invalid, or that carries `snp_cmd`=3 raises no flush and leaves the line unchanged.
- R11: A processor request to the index that a snoop presents in the same cycle is not completed in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address (low bits index the line) |
| cpu_wdata | input | DW | Write data |
| cpu_rdata | output | DW | Read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Arbitration request |
| bus_gnt | input | 1 | Grant pulse from the arbiter |
| bus_cmd | output | 2 | 0 none, 1 read miss, 2 write miss, 3 writeback |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Writeback data |
| bus_done | input | 1 | Transaction end; `bus_rdata` valid |
| bus_rdata | input | DW | Fill data |
| snp_valid | input | 1 | Another master's transaction starts |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | AW | Snooped address |
| snp_flush | output | 1 | This cache supplies dirty data now |
| snp_data | output | DW | Supplied data |

## Verification
On every cycle, the in-module properties check the following:
- The request is held until it is granted, and the command and address stay stable through a transaction.
- After a writeback the controller returns to arbitration.
- A flushed line is no longer Modified on the next cycle, and a write-miss fill leaves the line Modified.
- A snoop never coincides with the controller's own transaction.
- A completion always has a live request.

Only the bench's scenarios can show the rest:
- That the returned data is right.
- That hits really avoid the bus.
- That a Modified victim is written back with the right address and data before the miss.
- That snoops downgrade or invalidate lines, or leave them alone. These are checked against a line-state and memory model kept in the bench.

// File: rtl/msi_snoop_cache.sv
module msi_snoop_cache #(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int LINES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_ready,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_done,
  input  logic [DW-1:0] bus_rdata,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_flush,
  output logic [DW-1:0] snp_data
);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - IW;
  localparam logic [1:0] L_I = 2'd0, L_S = 2'd1, L_M = 2'd2;
  localparam logic [1:0] C_NONE = 2'd0, C_RD = 2'd1, C_WR = 2'd2, C_WB = 2'd3;

  typedef enum logic [1:0] {IDLE, ARB, XFER} fsm_t;

  fsm_t          fsm;
  logic [1:0]    cmd_q;
  logic [1:0]    lst  [LINES];
  logic [TW-1:0] ltag [LINES];
  logic [DW-1:0] ldat [LINES];

  logic [IW-1:0] cidx, sidx;
  logic [TW-1:0] ctag, stag;
  logic          c_match, c_hit, need_wb, snp_touch, s_hit;
  logic          hit_done, fill_done, xfer_end;

  assign cidx = cpu_addr[IW-1:0];
  assign ctag = cpu_addr[AW-1:IW];
  assign sidx = snp_addr[IW-1:0];
  assign stag = snp_addr[AW-1:IW];

  assign c_match   = ltag[cidx] == ctag;
  assign c_hit     = c_match && (cpu_we ? lst[cidx] == L_M : lst[cidx] != L_I);
  assign need_wb   = lst[cidx] == L_M && !c_match;
  assign snp_touch = snp_valid && sidx == cidx;
  assign s_hit     = snp_valid && (snp_cmd == C_RD || snp_cmd == C_WR) &&
                     ltag[sidx] == stag && lst[sidx] != L_I;

  assign hit_done  = fsm == IDLE && cpu_req && !snp_touch && c_hit;
  assign xfer_end  = fsm == XFER && bus_done;
  assign fill_done = xfer_end && cmd_q != C_WB;

  assign cpu_ready = hit_done || fill_done;
  assign cpu_rdata = fsm == XFER ? bus_rdata : ldat[cidx];
  assign bus_req   = fsm == ARB;
  assign bus_cmd   = fsm == XFER ? cmd_q : C_NONE;
  assign bus_addr  = cmd_q == C_WB ? {ltag[cidx], cidx} : cpu_addr;
  assign bus_wdata = ldat[cidx];
  assign snp_flush = s_hit && lst[sidx] == L_M;
  assign snp_data  = ldat[sidx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm   <= IDLE;
      cmd_q <= C_NONE;
    end else begin
      case (fsm)
        IDLE: if (cpu_req && !snp_touch && !c_hit) fsm <= ARB;
        ARB: if (bus_gnt) begin
          cmd_q <= need_wb ? C_WB : (cpu_we ? C_WR : C_RD);
          fsm   <= XFER;
        end
        XFER: if (bus_done) fsm <= cmd_q == C_WB ? ARB : IDLE;
        default: fsm <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) lst[i] <= L_I;
    end else begin
      if (s_hit) lst[sidx] <= snp_cmd == C_RD ? L_S : L_I;
      if (hit_done && cpu_we) lst[cidx] <= L_M;
      if (xfer_end) lst[cidx] <= cmd_q == C_WB ? L_I : (cmd_q == C_WR ? L_M : L_S);
    end
  end

  always_ff @(posedge clk) begin
    if (fill_done) ltag[cidx] <= ctag;
    if (hit_done && cpu_we) ldat[cidx] <= cpu_wdata;
    else if (fill_done) ldat[cidx] <= cmd_q == C_WR ? cpu_wdata : bus_rdata;
  end

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req);

  p_cmd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd != C_NONE && !bus_done |=> $stable(bus_cmd) && $stable(bus_addr));

  p_wb_rearb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd == C_WB && bus_done |=> bus_req);

  p_flush_leaves_m_r8: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |=> lst[$past(sidx)] != L_M);

  p_wr_fill_m_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd == C_WR && bus_done |=> lst[$past(cidx)] == L_M);

  p_snoop_serial_r9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> bus_cmd == C_NONE);

  p_ready_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req);

  p_touch_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    snp_touch && bus_cmd == C_NONE |-> !cpu_ready);
endmodule

// File: tb/sim_msi_snoop_cache.sv
module sim_msi_snoop_cache;
  localparam int AW = 8, DW = 32, LINES = 16, IW = 4;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_ready, bus_req, bus_gnt = 0, bus_done = 0;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata = '0;
  logic snp_valid = 0;
  logic [1:0] snp_cmd = 0;
  logic [AW-1:0] snp_addr = '0;
  logic snp_flush;
  logic [DW-1:0] snp_data;

  always #4 clk = ~clk;

  msi_snoop_cache #(.AW(AW), .DW(DW), .LINES(LINES)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_flush(snp_flush), .snp_data(snp_data));

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [DW-1:0] mem [1 << AW];
  int            m_st  [LINES];
  logic [AW-IW-1:0] m_tag [LINES];
  logic [DW-1:0] m_dat [LINES];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic serve(output logic [1:0] cmd, output logic [AW-1:0] a,
                       output logic [DW-1:0] wd, output logic rdy, output logic [DW-1:0] rd);
    int n = 0;
    while (!bus_req && n < 30) begin @(negedge clk); #1; n++; end
    chk(bus_req, "R6 request raised", bus_req, 1);
    repeat ($urandom_range(0, 2)) begin
      @(negedge clk); #1;
      chk(bus_req, "R6 request held", bus_req, 1);
    end
    bus_gnt = 1;
    @(negedge clk); bus_gnt = 0; #1;
    cmd = bus_cmd; a = bus_addr; wd = bus_wdata;
    repeat ($urandom_range(0, 2)) begin @(negedge clk); #1; end
    bus_rdata = mem[a];
    bus_done = 1; #1;
    rdy = cpu_ready; rd = cpu_rdata;
    @(negedge clk); bus_done = 0;
    if (cmd == 2'd3) mem[a] = wd;
  endtask

  task automatic cpu_op(input bit we, input logic [AW-1:0] addr, input logic [DW-1:0] wd);
    int idx = int'(addr[IW-1:0]);
    logic [AW-IW-1:0] tg = addr[AW-1:IW];
    bit hit = we ? (m_st[idx] == 2 && m_tag[idx] == tg) : (m_st[idx] != 0 && m_tag[idx] == tg);
    bit wb = !hit && m_st[idx] == 2 && m_tag[idx] != tg;
    logic [1:0] c; logic [AW-1:0] a; logic [DW-1:0] w, r, exp_r; logic rdy;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd; #1;
    if (hit) begin
      chk(cpu_ready == 1, we ? "R3 write hit ready" : "R2 read hit ready", cpu_ready, 1);
      if (!we) chk(cpu_rdata == m_dat[idx], "R2 read hit data", cpu_rdata, m_dat[idx]);
      @(negedge clk); cpu_req = 0; #1;
      chk(bus_req == 0, we ? "R3 hit uses no bus" : "R2 hit uses no bus", bus_req, 0);
      if (we) m_dat[idx] = wd;
    end else begin
      chk(cpu_ready == 0, "R4 miss stalls", cpu_ready, 0);
      if (wb) begin
        serve(c, a, w, rdy, r);
        chk(c == 2'd3, "R7 writeback first", c, 3);
        chk(a == {m_tag[idx], addr[IW-1:0]}, "R7 victim address", a, {m_tag[idx], addr[IW-1:0]});
        chk(w == m_dat[idx], "R7 victim data", w, m_dat[idx]);
        chk(rdy == 0, "R7 no ready on writeback", rdy, 0);
      end
      exp_r = mem[addr];
      serve(c, a, w, rdy, r);
      cpu_req = 0;
      chk(c == (we ? 2'd2 : 2'd1), we ? "R5 write miss command" : "R4 read miss command", c, we ? 2 : 1);
      chk(a == addr, "R4 miss address", a, addr);
      chk(rdy == 1, "R4 ready at done", rdy, 1);
      if (!we) chk(r == exp_r, "R4 fill data", r, exp_r);
      m_tag[idx] = tg;
      m_st[idx] = we ? 2 : 1;
      m_dat[idx] = we ? wd : exp_r;
    end
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] addr);
    int idx = int'(addr[IW-1:0]);
    bit match = m_st[idx] != 0 && m_tag[idx] == addr[AW-1:IW] && (cmd == 2'd1 || cmd == 2'd2);
    bit ef = match && m_st[idx] == 2;
    string lb = cmd == 2'd1 ? "R8 snoop read" : (cmd == 2'd2 ? "R9 snoop write" : "R10 snoop writeback");
    @(negedge clk);
    snp_valid = 1; snp_cmd = cmd; snp_addr = addr; #1;
    if (!match) lb = "R10 snoop no effect";
    chk(snp_flush == ef, lb, snp_flush, ef);
    if (ef) begin
      chk(snp_data == m_dat[idx], "R8 flush data", snp_data, m_dat[idx]);
      mem[addr] = m_dat[idx];
    end
    if (match) m_st[idx] = cmd == 2'd1 ? 1 : 0;
    @(negedge clk); snp_valid = 0;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    summary();
  end

  initial begin
    int dummy = $urandom(32'd2024);
    for (int i = 0; i < (1 << AW); i++) mem[i] = $urandom;
    for (int i = 0; i < LINES; i++) begin m_st[i] = 0; m_tag[i] = '0; m_dat[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    chk(cpu_ready == 0 && bus_req == 0 && bus_cmd == 0, "R1 reset outputs", {cpu_ready, bus_req, bus_cmd}, 0);
    // R1: first read after reset misses
    cpu_op(0, 8'h05, 0);
    cpu_op(0, 8'h05, 0);
    cpu_op(1, 8'h05, 32'hA5A5_0001);
    cpu_op(0, 8'h05, 0);
    cpu_op(1, 8'h05, 32'hA5A5_0002);
    cpu_op(0, 8'h15, 0);
    cpu_op(1, 8'h27, 32'hBEEF_0027);
    snoop(2'd1, 8'h27);
    cpu_op(0, 8'h27, 0);
    cpu_op(1, 8'h27, 32'hBEEF_1027);
    snoop(2'd2, 8'h27);
    cpu_op(0, 8'h27, 0);
    snoop(2'd1, 8'h37);
    snoop(2'd3, 8'h27);
    cpu_op(0, 8'h27, 0);
    snoop(2'd2, 8'h15);
    cpu_op(0, 8'h15, 0);
    // R11: snoop to the requested index stalls the hit for that cycle
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = 8'h27;
    snp_valid = 1; snp_cmd = 2'd3; snp_addr = 8'h47; #1;
    chk(cpu_ready == 0, "R11 same-index snoop stalls", cpu_ready, 0);
    @(negedge clk); snp_valid = 0; #1;
    chk(cpu_ready == 1, "R11 completes after snoop", cpu_ready, 1);
    @(negedge clk); cpu_req = 0;
    for (int k = 0; k < 400; k++) begin
      logic [AW-1:0] ad = AW'($urandom_range(0, 63));
      if ($urandom_range(0, 9) < 7) cpu_op($urandom_range(0, 1) == 1, ad, $urandom);
      else snoop(2'($urandom_range(1, 3)), ad);
    end
    repeat (2) @(negedge clk);
    summary();
  end
endmodule